// File: doc/BRIEF.md
# Idle-Timed PHY Sleep Controller

This block decides when a storage port's physical layer may be put to sleep. It watches two per-slot vectors: the commands that have been issued but not yet finished, and the queued tags that are still outstanding. When both vectors are empty the port is idle. An enable bit, which software can write, turns on automatic sleep. While that bit is set, an idle counter runs. The sleep output rises once the port has stayed idle for a programmed number of cycles.

While the enable bit is clear, the block never sleeps on its own. Only a software sleep request can put the PHY to sleep in that mode. The enable bit can be written only on hardware that has the aggressive-management capability, and it can hold 1 only while platform sleep support is valid. Platform sleep support is valid only when the sleep-support capability is also present. Any new port activity wakes the PHY and restarts the count. Clearing the enable bit also wakes the PHY.

Top module: `link_sleep_ctl`

## Requirements
- R1: The port is idle only when `cmd_issue` and `tag_active` are both all-zero. While either vector has a bit set, `phy_sleep` stays 0 however long that lasts.
- R2: With `aen_q`=1 and `idle_limit`=L, hold the port idle from a point just after a rising edge. `phy_sleep` is then 0 for the first L rising edges and 1 after rising edge L+1.
- R3: With `idle_limit`=0 and `aen_q`=1, `phy_sleep` is 1 after the first rising edge at which the port is idle.
- R4: A non-idle port at a rising edge forces `phy_sleep` to 0 at that edge and resets the idle count. A later idle stretch needs the full L+1 edges again.
- R5: While `aen_q`=0, `phy_sleep` never rises by itself. A one-cycle `sw_sleep_req`=1 sampled on an idle port sets `phy_sleep` at that edge, and it stays set while the port is idle.
- R6: While `cap_aggr`=0, writes through `aen_wr`/`aen_wdata` are ignored and `aen_q` reads 0.
- R7: While `plat_ok_q`=0, a write of 1 to the enable bit is ignored and `aen_q` reads 0.
- R8: `plat_ok_q` is 1 only when `plat_sleep_ok`=1 and `cap_sleep`=1.
- R9: When the enable bit goes from 1 to 0 while `phy_sleep`=1, `phy_sleep` is 0 after that same edge. It stays 0 on the still-idle port.
- R10: After reset, `phy_sleep`=0 and `aen_q`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_issue | input | SLOTS | Issued-command slot vector |
| tag_active | input | SLOTS | Outstanding queued-tag vector |
| idle_limit | input | CW | Idle timeout in cycles |
| plat_sleep_ok | input | 1 | Platform declares PHY sleep support |
| cap_sleep | input | 1 | Sleep-support capability present |
| cap_aggr | input | 1 | Aggressive-management capability present |
| sw_sleep_req | input | 1 | Software-directed sleep request (pulse) |
| aen_wr | input | 1 | Write strobe for the enable bit |
| aen_wdata | input | 1 | Value written to the enable bit |
| aen_q | output | 1 | Current enable bit |
| plat_ok_q | output | 1 | Effective platform sleep support |
| phy_sleep | output | 1 | PHY sleep output |

## Verification
A wrong idle count shows up as `phy_sleep` rising one or more edges early or late against L+1, so the edge-by-edge checks around the expiry point catch it at once. A stale sleep state or enable bit appears one edge after activity resumes or after the enable bit is cleared, as a sleep output that fails to drop. Gating faults in the enable bit show as `aen_q` reading 1 one edge after a write that should have been refused.

// File: rtl/link_sleep_ctl.sv
module link_sleep_ctl #(
  parameter int SLOTS = 32,
  parameter int CW    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SLOTS-1:0] cmd_issue,
  input  logic [SLOTS-1:0] tag_active,
  input  logic [CW-1:0]    idle_limit,
  input  logic             plat_sleep_ok,
  input  logic             cap_sleep,
  input  logic             cap_aggr,
  input  logic             sw_sleep_req,
  input  logic             aen_wr,
  input  logic             aen_wdata,
  output logic             aen_q,
  output logic             plat_ok_q,
  output logic             phy_sleep
);

  logic          idle;
  logic          aen_r, aen_nx, aen_fall, expire, sleep_r, sleep_nx;
  logic [CW-1:0] cnt;

  assign idle      = ~|cmd_issue && ~|tag_active;
  assign plat_ok_q = plat_sleep_ok & cap_sleep;

  always_comb begin
    aen_nx = aen_r;
    if (aen_wr) aen_nx = aen_wdata;
    if (!cap_aggr || !plat_ok_q) aen_nx = 1'b0;
  end

  assign aen_fall = aen_r & ~aen_nx;
  assign expire   = aen_r && idle && (cnt >= idle_limit);

  always_comb begin
    sleep_nx = sleep_r;
    if (!idle)             sleep_nx = 1'b0;
    else if (aen_fall)     sleep_nx = 1'b0;
    else if (sw_sleep_req) sleep_nx = 1'b1;
    else if (expire)       sleep_nx = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aen_r   <= 1'b0;
      sleep_r <= 1'b0;
      cnt     <= '0;
    end else begin
      aen_r   <= aen_nx;
      sleep_r <= sleep_nx;
      if (!idle || !aen_r)       cnt <= '0;
      else if (cnt < idle_limit) cnt <= cnt + 1'b1;
    end
  end

  assign aen_q     = aen_r;
  assign phy_sleep = sleep_r;

endmodule

module link_sleep_ctl_chk #(
  parameter int SLOTS = 32,
  parameter int CW    = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [SLOTS-1:0] cmd_issue,
  input logic [SLOTS-1:0] tag_active,
  input logic             cap_aggr,
  input logic             sw_sleep_req,
  input logic             aen_q,
  input logic             plat_ok_q,
  input logic             phy_sleep
);
  logic idle_c;
  assign idle_c = (cmd_issue == '0) && (tag_active == '0);

  p_busy_wake_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !idle_c |=> !phy_sleep);
  p_rise_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phy_sleep) |-> $past(idle_c));
  p_cap_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_aggr |=> !aen_q);
  p_plat_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !plat_ok_q |=> !aen_q);
  p_no_auto_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!aen_q && !sw_sleep_req && !phy_sleep) |=> !phy_sleep);
  p_clear_wake_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(aen_q) |-> !phy_sleep);
endmodule

bind link_sleep_ctl link_sleep_ctl_chk #(.SLOTS(SLOTS), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_issue(cmd_issue), .tag_active(tag_active),
  .cap_aggr(cap_aggr), .sw_sleep_req(sw_sleep_req), .aen_q(aen_q),
  .plat_ok_q(plat_ok_q), .phy_sleep(phy_sleep)
);

// File: tb/link_sleep_ctl_tb.sv
module link_sleep_ctl_tb;
  localparam int SLOTS = 32;
  localparam int CW    = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [SLOTS-1:0] cmd_issue = '0;
  logic [SLOTS-1:0] tag_active = '0;
  logic [CW-1:0]    idle_limit = '0;
  logic             plat_sleep_ok = 1'b0, cap_sleep = 1'b0, cap_aggr = 1'b0;
  logic             sw_sleep_req = 1'b0, aen_wr = 1'b0, aen_wdata = 1'b0;
  logic             aen_q, plat_ok_q, phy_sleep;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  link_sleep_ctl #(.SLOTS(SLOTS), .CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_issue(cmd_issue), .tag_active(tag_active),
    .idle_limit(idle_limit), .plat_sleep_ok(plat_sleep_ok), .cap_sleep(cap_sleep),
    .cap_aggr(cap_aggr), .sw_sleep_req(sw_sleep_req), .aen_wr(aen_wr),
    .aen_wdata(aen_wdata), .aen_q(aen_q), .plat_ok_q(plat_ok_q), .phy_sleep(phy_sleep)
  );

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic write_aen(input logic v);
    @(negedge clk); aen_wr = 1'b1; aen_wdata = v;
    @(negedge clk); aen_wr = 1'b0;
  endtask

  task automatic go_busy();
    @(negedge clk); cmd_issue = 32'h1;
  endtask

  task automatic go_idle();
    @(negedge clk); cmd_issue = '0; tag_active = '0;
  endtask

  task automatic t_reset();
    #1;
    check("R10 sleep", phy_sleep, 1'b0);
    check("R10 aen", aen_q, 1'b0);
  endtask

  task automatic t_plat();
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); plat_sleep_ok = i[0]; cap_sleep = i[1]; #1;
      check("R8 plat_ok", plat_ok_q, i[0] & i[1]);
    end
  endtask

  task automatic t_cap_block();
    plat_sleep_ok = 1'b1; cap_sleep = 1'b1; cap_aggr = 1'b0;
    write_aen(1'b1); #1;
    check("R6 aen locked", aen_q, 1'b0);
  endtask

  task automatic t_plat_block();
    cap_aggr = 1'b1; plat_sleep_ok = 1'b0;
    write_aen(1'b1); #1;
    check("R7 aen refused", aen_q, 1'b0);
    plat_sleep_ok = 1'b1;
  endtask

  task automatic t_auto(input int lim);
    go_busy(); idle_limit = CW'(lim);
    write_aen(1'b1);
    check("R2 aen set", aen_q, 1'b1);
    go_idle();
    if (lim > 0) begin
      edges(lim);
      check("R2 before expiry", phy_sleep, 1'b0);
      edges(1);
      check("R2 at expiry", phy_sleep, 1'b1);
    end else begin
      edges(1);
      check("R3 zero limit", phy_sleep, 1'b1);
    end
  endtask

  task automatic t_busy_restart(input int lim);
    @(negedge clk); tag_active = 32'h8000_0000;
    edges(1);
    check("R4 wake on activity", phy_sleep, 1'b0);
    edges(12);
    check("R1 tag busy holds awake", phy_sleep, 1'b0);
    @(negedge clk); tag_active = '0; cmd_issue = 32'h4;
    edges(12);
    check("R1 cmd busy holds awake", phy_sleep, 1'b0);
    go_idle();
    edges(lim);
    check("R4 restarted count", phy_sleep, 1'b0);
    edges(1);
    check("R4 full timeout again", phy_sleep, 1'b1);
  endtask

  task automatic t_clear();
    write_aen(1'b0);
    check("R9 wake on clear", phy_sleep, 1'b0);
    edges(10);
    check("R9 stays awake", phy_sleep, 1'b0);
  endtask

  task automatic t_manual();
    idle_limit = CW'(2);
    go_busy(); go_idle();
    edges(20);
    check("R5 no auto sleep", phy_sleep, 1'b0);
    @(negedge clk); sw_sleep_req = 1'b1;
    @(negedge clk); sw_sleep_req = 1'b0;
    check("R5 manual sleep", phy_sleep, 1'b1);
    edges(5);
    check("R5 manual holds", phy_sleep, 1'b1);
    go_busy(); edges(1);
    check("R5 manual wake on busy", phy_sleep, 1'b0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_plat();
    t_cap_block();
    t_plat_block();
    t_auto(5);
    t_busy_restart(5);
    t_clear();
    t_auto(0);
    t_clear();
    t_manual();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule